// File: doc/BRIEF.md
# Iterative Euler Integrator for dy/dt = (t - y)^2

This block integrates the differential equation dy/dt = (t - y)^2 with the explicit Euler method. Integration begins at t = 0 with y = 1.0 and ends at t = 3.0. A caller sets the step size on `h_in` and pulses `start`. The block then steps through the interval and reports the final y on `y_out`, together with a one-cycle `done` pulse.

Each step needs the y produced by the step before it, so the steps cannot overlap. The block is a small sequencer that time-shares one fixed-point multiplier and one saturating adder/subtractor. It waits for each multiply to finish before it issues the next operation. The run length therefore grows with the number of steps, which is about 3/h, and with the multiplier latency.

Top module: `euler_stepper`

## Requirements
- R1: After reset, `done` is low and `y_out` is 0.
- R2: Values are signed Q8.16: 24-bit two's complement with 16 fraction bits, so 1.0 is 0x010000. Each step does y <- y + h*(t - y)^2, then t <- t + h, starting from t = 0 and y = 1.0. Every product is rounded to nearest with halves rounded up, then saturated to 24 bits. Every sum or difference is saturated to 24 bits.
- R3: A step is taken only while t + h <= 3.0, and a step that lands exactly on t = 3.0 is taken. The run ends at the first check where t + h > 3.0, so t never exceeds 3.0.
- R4: A single multiplier with `MUL_LAT` cycles of latency is shared, and no multiply is issued while one is in flight. For h > 0, a run of n steps raises `done` exactly n*(5 + 2*MUL_LAT) + 1 clock edges after the edge that accepted `start`.
- R5: Each accepted start produces exactly one `done` pulse, one cycle wide, and `y_out` carries the result in that cycle.
- R6: `y_out` changes only in a cycle where `done` is high. At all other times it holds the previous result, including while a later run is in progress.
- R7: A `start` that arrives while a run is in progress is ignored. `h_in` is sampled only at an accepted start, so later changes to it have no effect on the run.
- R8: A zero or negative h produces `done` on the clock edge that accepts `start`, with `y_out` = 1.0 (0x010000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| h_in | input | 24 | Step size, signed Q8.16 |
| y_out | output | 24 | Final y of the last run, signed Q8.16 |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions check four properties on every cycle:
- `done` never stays high for two cycles.
- `y_out` never moves without `done`.
- The latched step size stays fixed while a `start` arrives during a run.
- t stays within [0, 3.0], and the multiplier never receives a new operand while one is in flight.

The bench scenarios cover what a per-cycle property cannot see:
- Results that match an independent Euler model, including the step that lands exactly on 3.0 and the step size that overshoots it.
- The exact run length, which shows that the sequencer stalls for the multiplier's full latency.
- The handling of zero and negative step sizes.
- The fact that a start issued mid-run leaves both the result and the run length unchanged.

// File: rtl/euler_pkg.sv
package euler_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DIFF,
    ST_SQ,
    ST_SQ_W,
    ST_SCL,
    ST_SCL_W,
    ST_ACC
  } step_state_t;

endpackage

// File: rtl/fx_addsub.sv
module fx_addsub #(
  parameter int W = 24
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                sub,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide;

  always_comb begin
    wide = sub ? ({a[W-1], a} - {b[W-1], b}) : ({a[W-1], a} + {b[W-1], b});
    if (wide[W] != wide[W-1])
      y = wide[W] ? MINV : MAXV;
    else
      y = wide[W-1:0];
  end
endmodule

// File: rtl/fx_mul.sv
module fx_mul #(
  parameter int W       = 24,
  parameter int F       = 16,
  parameter int LATENCY = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] p,
  output logic                valid,
  output logic                busy
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] HI  = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] LO  = ~HI;
  localparam logic signed [PW-1:0] RND = {{(PW-F){1'b0}}, 1'b1, {(F-1){1'b0}}};

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] rnd;
  logic signed [W-1:0]  sat;

  always_comb begin
    full = PW'(a) * PW'(b);
    rnd  = (full + RND) >>> F;
    if (rnd > HI)      sat = HI[W-1:0];
    else if (rnd < LO) sat = LO[W-1:0];
    else               sat = rnd[W-1:0];
  end

  logic signed [W-1:0] p_pipe [LATENCY];
  logic [LATENCY-1:0]  v_pipe;

  always_ff @(posedge clk) begin
    if (rst) v_pipe[0] <= 1'b0;
    else     v_pipe[0] <= issue;
    if (issue) p_pipe[0] <= sat;
  end

  for (genvar i = 1; i < LATENCY; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) v_pipe[i] <= 1'b0;
      else     v_pipe[i] <= v_pipe[i-1];
      p_pipe[i] <= p_pipe[i-1];
    end
  end

  assign p     = p_pipe[LATENCY-1];
  assign valid = v_pipe[LATENCY-1];
  assign busy  = |v_pipe;
endmodule

// File: rtl/euler_stepper.sv
module euler_stepper #(
  parameter int INT_BITS  = 8,
  parameter int FRAC_BITS = 16,
  parameter int MUL_LAT   = 2,
  parameter int T_END_INT = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  start,
  input  logic signed [INT_BITS+FRAC_BITS-1:0]  h_in,
  output logic signed [INT_BITS+FRAC_BITS-1:0]  y_out,
  output logic                                  done
);
  import euler_pkg::*;

  localparam int W = INT_BITS + FRAC_BITS;
  localparam logic signed [W-1:0] ONE_FX = W'(1) << FRAC_BITS;
  localparam logic signed [W-1:0] T_END  = W'(T_END_INT) << FRAC_BITS;

  step_state_t state;
  logic signed [W-1:0] t_q, y_q, h_q, t_nx, d_q, prod_q;

  // shared adder
  logic signed [W-1:0] add_a, add_b, add_y;
  logic                add_sub;

  always_comb begin
    case (state)
      ST_CHECK: begin add_a = t_q; add_b = h_q;    add_sub = 1'b0; end
      ST_DIFF:  begin add_a = t_q; add_b = y_q;    add_sub = 1'b1; end
      default:  begin add_a = y_q; add_b = prod_q; add_sub = 1'b0; end
    endcase
  end

  fx_addsub #(.W(W)) u_add (
    .a(add_a), .b(add_b), .sub(add_sub), .y(add_y)
  );

  // shared multiplier
  logic signed [W-1:0] mul_a, mul_b, mul_p;
  logic                mul_issue, mul_valid, mul_busy;

  assign mul_issue = (state == ST_SQ) || (state == ST_SCL);
  assign mul_a     = (state == ST_SQ) ? d_q : h_q;
  assign mul_b     = (state == ST_SQ) ? d_q : prod_q;

  fx_mul #(.W(W), .F(FRAC_BITS), .LATENCY(MUL_LAT)) u_mul (
    .clk(clk), .rst(rst), .issue(mul_issue), .a(mul_a), .b(mul_b),
    .p(mul_p), .valid(mul_valid), .busy(mul_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      y_out  <= '0;
      t_q    <= '0;
      y_q    <= '0;
      h_q    <= '0;
      t_nx   <= '0;
      d_q    <= '0;
      prod_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            h_q <= h_in;
            if (h_in <= 0) begin
              y_out <= ONE_FX;
              done  <= 1'b1;
            end else begin
              t_q   <= '0;
              y_q   <= ONE_FX;
              state <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (add_y > T_END) begin
            y_out <= y_q;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            t_nx  <= add_y;
            state <= ST_DIFF;
          end
        end
        ST_DIFF: begin
          d_q   <= add_y;
          state <= ST_SQ;
        end
        ST_SQ:  state <= ST_SQ_W;
        ST_SQ_W: begin
          if (mul_valid) begin
            prod_q <= mul_p;
            state  <= ST_SCL;
          end
        end
        ST_SCL: state <= ST_SCL_W;
        ST_SCL_W: begin
          if (mul_valid) begin
            prod_q <= mul_p;
            state  <= ST_ACC;
          end
        end
        ST_ACC: begin
          y_q   <= add_y;
          t_q   <= t_nx;
          state <= ST_CHECK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: time never passes the end of the interval
  a_r3_t_in_range: assert property (@(posedge clk) disable iff (rst)
    (t_q >= 0) && (t_q <= T_END));

  // R4: multiplier is never handed new operands with one in flight
  a_r4_one_mul_in_flight: assert property (@(posedge clk) disable iff (rst)
    mul_issue |-> !mul_busy);

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: result only moves together with done
  a_r6_y_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(y_out) |-> done);

  // R7: a start during a run leaves the latched step size alone
  a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> $stable(h_q));
endmodule

// File: tb/euler_stepper_test.sv
module euler_stepper_test;
  localparam int CLK_PERIOD = 10;
  localparam int W         = 24;
  localparam int F         = 16;
  localparam int MUL_LAT   = 2;
  localparam longint ONE   = 64'sd1 <<< F;
  localparam longint T_END = 64'sd3 <<< F;
  localparam longint MAXV  = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV  = -(64'sd1 <<< (W-1));
  localparam int WATCHDOG  = 150000;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic signed [W-1:0] h_in;
  logic signed [W-1:0] y_out;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  euler_stepper #(.INT_BITS(W-F), .FRAC_BITS(F), .MUL_LAT(MUL_LAT), .T_END_INT(3)) uut (
    .clk(clk), .rst(rst), .start(start), .h_in(h_in), .y_out(y_out), .done(done)
  );

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint mulr(input longint a, input longint b);
    longint p;
    p = a * b;
    return sat((p + (64'sd1 <<< (F-1))) >>> F);
  endfunction

  function automatic longint model_y(input longint h);
    longint t, y, d, sq, inc;
    if (h <= 0) return ONE;
    t = 0;
    y = ONE;
    while (t + h <= T_END) begin
      d   = sat(t - y);
      sq  = mulr(d, d);
      inc = mulr(h, sq);
      y   = sat(y + inc);
      t   = t + h;
    end
    return y;
  endfunction

  function automatic longint model_steps(input longint h);
    if (h <= 0) return 0;
    return T_END / h;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input longint h);
    @(negedge clk);
    start = 1'b1;
    h_in  = W'(h);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_and_check(input string tag, input longint h, input bit check_len);
    int cyc;
    longint exp_y;
    exp_y = model_y(h);
    pulse_start(h);
    wait_done(cyc);
    check("R2", {tag, " final y"}, longint'(y_out), exp_y);
    if (check_len)
      check("R4", {tag, " run length"}, cyc, model_steps(h) * (5 + 2*MUL_LAT) + 1);
    @(negedge clk);
    check("R5", {tag, " done width"}, done, 0);
    repeat (6) @(negedge clk);
    check("R6", {tag, " y held"}, longint'(y_out), exp_y);
  endtask

  task automatic t_reset;
    check("R1", "reset done", done, 0);
    check("R1", "reset y", longint'(y_out), 0);
  endtask

  task automatic t_half_step;
    run_and_check("h=0.5", 64'sd32768, 1'b1);
    check("R2", "h=0.5 closed form", longint'(y_out), 4 * ONE);
  endtask

  task automatic t_fine_step;
    run_and_check("h=655", 64'sd655, 1'b1);
  endtask

  task automatic t_uneven_step;
    run_and_check("h=0.7", 64'sd45875, 1'b1);
  endtask

  task automatic t_exact_end;
    // R3: t + h == 3.0 exactly is still taken
    run_and_check("h=3.0", T_END, 1'b1);
    check("R3", "landing on 3.0 gives one step", longint'(y_out), 4 * ONE);
  endtask

  task automatic t_past_end;
    // R3: overshooting step is not taken
    run_and_check("h=3.0+lsb", T_END + 1, 1'b1);
    check("R3", "overshoot gives zero steps", longint'(y_out), ONE);
  endtask

  task automatic t_nonpositive(input longint h);
    // R8: done on the edge that accepts start
    pulse_start(h);
    check("R8", "nonpositive h done", done, 1);
    check("R8", "nonpositive h y", longint'(y_out), ONE);
    @(negedge clk);
    check("R5", "nonpositive h done width", done, 0);
  endtask

  task automatic t_busy_start;
    int cyc;
    longint prev;
    int extra;
    prev = longint'(y_out);
    pulse_start(64'sd16384);
    repeat (20) @(negedge clk);
    check("R6", "y held mid-run", longint'(y_out), prev);
    start = 1'b1;
    h_in  = W'(64'sd65536);
    @(negedge clk);
    start = 1'b0;
    h_in  = W'(-64'sd5);
    wait_done(cyc);
    check("R7", "busy start ignored, y", longint'(y_out), model_y(64'sd16384));
    check("R7", "busy start ignored, length", cyc + 21,
          model_steps(64'sd16384) * (5 + 2*MUL_LAT) + 1);
    extra = 0;
    @(negedge clk);
    repeat (200) begin
      if (done) extra++;
      @(negedge clk);
    end
    check("R7", "no second run", extra, 0);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst   = 1'b1;
    start = 1'b0;
    h_in  = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_half_step();
    t_fine_step();
    t_uneven_step();
    t_exact_end();
    t_past_end();
    t_nonpositive(64'sd0);
    t_nonpositive(-64'sd32768);
    t_busy_start();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule